// File: doc/BRIEF.md
# ADC Conversion Sequencer

This controller drives a 13-bit successive-approximation converter from a programmed list of up to 24 conversion slots. Each slot names one of 16 input channels. The controller sends the channel to the input mux, along with that channel's differential and gain settings. It produces the converter clock by dividing the core clock. Each slot is converted twice. The mean of the two codes is written into the result buffer that has the slot's index, formatted by the channel's alignment bit.

A start command launches a run. In single mode the controller walks the list once and then parks in a shutdown state. In this state the converter clock is held low. In continuous mode the controller wraps from the last slot back to slot 0 and never stops. A data-available flag counts stored samples against a programmable threshold. Software clears the flag, and an accepted start also clears it. The analog converter is outside the block. Its code arrives on `code_i` and is sampled at the end of each conversion.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The converter clock period is 8 + `div_sel_i` core cycles. `adc_clk_o` toggles only during a conversion. It is low for the first half of each period, meaning counts below (8 + `div_sel_i`)/2 rounded down, and high for the rest. A conversion spans 15 converter-clock periods.
- R2: `conv_go_o` is a one-cycle pulse in the first cycle of each conversion. With extension off, consecutive pulses within a run are 1 + 15·(8 + `div_sel_i`) + 4 cycles apart: one acquisition cycle, the conversion, and 4 processing cycles.
- R3: Every slot is converted twice. The stored value is derived from (first code + second code) >> 1, with the 14-bit sum truncated.
- R4: Channel config bit 3 (left) set stores the 13-bit mean shifted up by 3 with zeros below. Clear stores it zero-extended in bits 12:0.
- R5: Slot k writes buffer k. `rd_data_o` shows buffer `rd_idx_i` combinationally. Indices 24 and above read 0, and every buffer reads 0 after reset.
- R6: In single mode (`cont_i` = 0 at start), the controller enters shutdown 124 cycles after the last slot's second `conv_go_o`, assuming `div_sel_i` = 0. In shutdown `shdn_o` = 1, `busy_o` = 0 and `adc_clk_o` stays 0.
- R7: In continuous mode, after slot `seq_last_i` the next conversion is slot 0 again, and the run never reaches shutdown. Each later sweep overwrites the buffers with new means.
- R8: During a slot, `mux_sel_o` equals the slot's entry in `seq_ch_i`, found at bits [4k+3:4k]. `diff_o` and `gain_o` come from that channel's 5-bit config at `ch_cfg_i[5c+4:5c]`, laid out as bit 4 diff, bit 3 left, bit 2 ext and bits 1:0 gain.
- R9: When the channel's ext bit (bit 2) is set, the acquisition phase lasts 1 + `acq_ext_i` cycles instead of 1. When the bit is clear, `acq_ext_i` has no effect.
- R10: `dai_o` sets when the number of stores since the last set or start reaches `dai_thr_i` (0 acts as 1), and it stays set. `dai_clr_i` clears it, and an accepted start clears both the flag and the count.
- R11: A `start_i` pulse while `busy_o` = 1 is ignored. The run keeps its slot order and length, and `dai_o` is not cleared.
- R12: After reset `busy_o`, `shdn_o`, `dai_o`, `conv_go_o` and `adc_clk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| cont_i | input | 1 | 1 = continuous mode, 0 = single run then shutdown (latched at start) |
| div_sel_i | input | 4 | Converter clock ratio minus 8 |
| acq_ext_i | input | 8 | Extra acquisition cycles for channels with ext set |
| seq_last_i | input | 5 | Index of last slot in the list (latched at start, clamped to 23) |
| seq_ch_i | input | 96 | Channel number per slot, 4 bits each |
| ch_cfg_i | input | 80 | Config per channel, 5 bits each |
| dai_thr_i | input | 8 | Stores per data-available event |
| dai_clr_i | input | 1 | Clears the data-available flag |
| code_i | input | 13 | Converter output code |
| rd_idx_i | input | 5 | Result buffer read index |
| adc_clk_o | output | 1 | Converter clock |
| conv_go_o | output | 1 | Conversion start pulse |
| mux_sel_o | output | 4 | Input mux channel |
| diff_o | output | 1 | Differential mode for current channel |
| gain_o | output | 2 | Full-scale range select for current channel |
| busy_o | output | 1 | Run in progress |
| shdn_o | output | 1 | Shutdown state after a single run |
| dai_o | output | 1 | Data-available flag |
| rd_data_o | output | 16 | Result buffer read data |

## Verification
Every timing result is counted from `conv_go_o`. The bench samples on falling edges and stamps each pulse with its own rising-edge counter. It then demands exact gaps: 125 cycles at the fastest ratio, 155 or 160 cycles with ratio 10 and extension off or on, and 124 cycles from the final pulse to shutdown. Each buffer is read once its store has certainly happened, which is after the next pulse or after shutdown. The expected value comes from the bench's own code generator, which advances on every pulse. The data-available flag is sampled at the pulse that follows each store. This places the set between the third store and the fourth conversion pair.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACQ  = 3'd1,
    ST_CONV = 3'd2,
    ST_PROC = 3'd3,
    ST_SHUT = 3'd4
  } seq_st_e;

  typedef struct packed {
    logic       diff;
    logic       left;
    logic       ext;
    logic [1:0] gain;
  } ch_cfg_t;

  localparam int unsigned CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned MIN_RATIO = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             tick_o,
  output logic             adc_clk_o
);
  localparam int unsigned CNT_W = DIV_W + 4;

  logic [CNT_W-1:0] ratio_m1, half, cnt_q;

  assign ratio_m1  = CNT_W'(MIN_RATIO - 1) + CNT_W'(div_sel_i);
  assign half      = (ratio_m1 + CNT_W'(1)) >> 1;
  assign tick_o    = run_i && (cnt_q == ratio_m1);
  assign adc_clk_o = run_i && (cnt_q >= half);

  // counter restarts at every conversion so each one spans whole periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_BUF  = 24,
  parameter int unsigned IDX_W    = 5,
  parameter int unsigned EXT_W    = 8,
  parameter int unsigned CONV_CYC = 15,
  parameter int unsigned PROC_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [IDX_W-1:0] seq_last_i,
  input  logic [EXT_W-1:0] acq_ext_i,
  input  logic             ext_en_i,
  input  logic             tick_i,
  output seq_st_e          state_o,
  output logic [IDX_W-1:0] slot_o,
  output logic             pass_o,
  output logic             capture_o,
  output logic             store_o,
  output logic             start_acc_o,
  output logic             conv_go_o
);
  localparam int unsigned TCK_W = $clog2(CONV_CYC + 1);
  localparam int unsigned PRC_W = $clog2(PROC_CYC + 1);
  localparam logic [IDX_W-1:0] LAST_MAX = IDX_W'(NUM_BUF - 1);

  seq_st_e          st_q;
  logic [IDX_W-1:0] slot_q, last_q;
  logic             pass_q, cont_q, go_q;
  logic [EXT_W-1:0] acq_cnt;
  logic [TCK_W-1:0] tck_cnt;
  logic [PRC_W-1:0] prc_cnt;
  logic             idle, acq_done, conv_done, proc_done;

  assign idle        = (st_q == ST_IDLE) || (st_q == ST_SHUT);
  assign start_acc_o = start_i && idle;
  assign acq_done    = (st_q == ST_ACQ) && (!ext_en_i || acq_cnt == acq_ext_i);
  assign conv_done   = (st_q == ST_CONV) && tick_i && (tck_cnt == TCK_W'(CONV_CYC - 1));
  assign proc_done   = (st_q == ST_PROC) && (prc_cnt == PRC_W'(PROC_CYC - 1));

  assign state_o   = st_q;
  assign slot_o    = slot_q;
  assign pass_o    = pass_q;
  assign capture_o = conv_done;
  assign store_o   = proc_done && pass_q;
  assign conv_go_o = go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      slot_q  <= '0;
      last_q  <= '0;
      pass_q  <= 1'b0;
      cont_q  <= 1'b0;
      go_q    <= 1'b0;
      acq_cnt <= '0;
      tck_cnt <= '0;
      prc_cnt <= '0;
    end else begin
      go_q <= acq_done;
      unique case (st_q)
        ST_IDLE, ST_SHUT: begin
          if (start_i) begin
            st_q    <= ST_ACQ;
            slot_q  <= '0;
            pass_q  <= 1'b0;
            acq_cnt <= '0;
            cont_q  <= cont_i;
            last_q  <= (seq_last_i > LAST_MAX) ? LAST_MAX : seq_last_i;
          end
        end
        ST_ACQ: begin
          if (acq_done) begin
            st_q    <= ST_CONV;
            tck_cnt <= '0;
          end else begin
            acq_cnt <= acq_cnt + EXT_W'(1);
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            st_q    <= ST_PROC;
            prc_cnt <= '0;
          end else if (tick_i) begin
            tck_cnt <= tck_cnt + TCK_W'(1);
          end
        end
        ST_PROC: begin
          if (proc_done) begin
            acq_cnt <= '0;
            pass_q  <= ~pass_q;
            if (!pass_q) begin
              st_q <= ST_ACQ;
            end else if (slot_q == last_q) begin
              slot_q <= '0;
              st_q   <= cont_q ? ST_ACQ : ST_SHUT;
            end else begin
              slot_q <= slot_q + IDX_W'(1);
              st_q   <= ST_ACQ;
            end
          end else begin
            prc_cnt <= prc_cnt + PRC_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_avg_fmt.sv
module adc_avg_fmt #(
  parameter int unsigned CODE_W = 13,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              pass_i,
  input  logic              left_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PAD_W = DATA_W - CODE_W;

  logic [CODE_W-1:0] code_a_q, code_b_q, avg;
  logic [CODE_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_a_q <= '0;
      code_b_q <= '0;
    end else if (capture_i) begin
      if (pass_i) code_b_q <= code_i;
      else        code_a_q <= code_i;
    end
  end

  assign sum    = {1'b0, code_a_q} + {1'b0, code_b_q};
  assign avg    = sum[CODE_W:1];
  assign data_o = left_i ? {avg, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, avg};
endmodule

// File: rtl/adc_res_bank.sv
module adc_res_bank #(
  parameter int unsigned NUM_BUF = 24,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned IDX_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))         mem_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (ridx_i == IDX_W'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned NUM_BUF  = 24,
  parameter int unsigned CODE_W   = 13,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned EXT_W    = 8,
  parameter int unsigned SMP_W    = 8,
  parameter int unsigned CONV_CYC = 15,
  parameter int unsigned PROC_CYC = 4,
  localparam int unsigned CH_W    = $clog2(NUM_CH),
  localparam int unsigned IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      cont_i,
  input  logic [DIV_W-1:0]          div_sel_i,
  input  logic [EXT_W-1:0]          acq_ext_i,
  input  logic [IDX_W-1:0]          seq_last_i,
  input  logic [NUM_BUF*CH_W-1:0]   seq_ch_i,
  input  logic [NUM_CH*CFG_W-1:0]   ch_cfg_i,
  input  logic [SMP_W-1:0]          dai_thr_i,
  input  logic                      dai_clr_i,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic                      adc_clk_o,
  output logic                      conv_go_o,
  output logic [CH_W-1:0]           mux_sel_o,
  output logic                      diff_o,
  output logic [1:0]                gain_o,
  output logic                      busy_o,
  output logic                      shdn_o,
  output logic                      dai_o,
  output logic [DATA_W-1:0]         rd_data_o
);
  seq_st_e           st;
  logic [IDX_W-1:0]  slot;
  logic [CH_W-1:0]   cur_ch;
  ch_cfg_t           cur_cfg;
  logic              pass, capture, store, start_acc, tick;
  logic [DATA_W-1:0] wdata;
  logic [SMP_W-1:0]  smp_cnt_q;
  logic              dai_q, thr_hit;

  assign cur_ch  = seq_ch_i[int'(slot)*CH_W +: CH_W];
  assign cur_cfg = ch_cfg_t'(ch_cfg_i[int'(cur_ch)*CFG_W +: CFG_W]);

  assign mux_sel_o = cur_ch;
  assign diff_o    = cur_cfg.diff;
  assign gain_o    = cur_cfg.gain;
  assign busy_o    = (st == ST_ACQ) || (st == ST_CONV) || (st == ST_PROC);
  assign shdn_o    = (st == ST_SHUT);
  assign dai_o     = dai_q;

  adc_clk_div #(
    .DIV_W    (DIV_W),
    .MIN_RATIO(8)
  ) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (st == ST_CONV),
    .div_sel_i(div_sel_i),
    .tick_o   (tick),
    .adc_clk_o(adc_clk_o)
  );

  adc_seq_fsm #(
    .NUM_BUF (NUM_BUF),
    .IDX_W   (IDX_W),
    .EXT_W   (EXT_W),
    .CONV_CYC(CONV_CYC),
    .PROC_CYC(PROC_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cont_i     (cont_i),
    .seq_last_i (seq_last_i),
    .acq_ext_i  (acq_ext_i),
    .ext_en_i   (cur_cfg.ext),
    .tick_i     (tick),
    .state_o    (st),
    .slot_o     (slot),
    .pass_o     (pass),
    .capture_o  (capture),
    .store_o    (store),
    .start_acc_o(start_acc),
    .conv_go_o  (conv_go_o)
  );

  adc_avg_fmt #(
    .CODE_W(CODE_W),
    .DATA_W(DATA_W)
  ) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .pass_i   (pass),
    .left_i   (cur_cfg.left),
    .code_i   (code_i),
    .data_o   (wdata)
  );

  adc_res_bank #(
    .NUM_BUF(NUM_BUF),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (store),
    .widx_i (slot),
    .wdata_i(wdata),
    .ridx_i (rd_idx_i),
    .rdata_o(rd_data_o)
  );

  // threshold 0 behaves as 1
  assign thr_hit = ({1'b0, smp_cnt_q} + (SMP_W+1)'(1)) >= {1'b0, dai_thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dai_q     <= 1'b0;
      smp_cnt_q <= '0;
    end else if (start_acc) begin
      dai_q     <= 1'b0;
      smp_cnt_q <= '0;
    end else if (store) begin
      if (thr_hit) begin
        dai_q     <= 1'b1;
        smp_cnt_q <= '0;
      end else begin
        smp_cnt_q <= smp_cnt_q + SMP_W'(1);
        if (dai_clr_i) dai_q <= 1'b0;
      end
    end else if (dai_clr_i) begin
      dai_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned CH_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            dai_clr_i,
  input logic            busy_o,
  input logic            shdn_o,
  input logic            adc_clk_o,
  input logic            conv_go_o,
  input logic            dai_o,
  input logic [CH_W-1:0] mux_sel_o
);
  AST_SHDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_o |-> (!busy_o && !adc_clk_o)); // R6

  AST_CLK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_o |-> busy_o); // R1

  AST_CLK_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_clk_o) |=> adc_clk_o ##1 adc_clk_o ##1 adc_clk_o); // R1

  AST_GO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> !conv_go_o); // R2

  AST_MUX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> $stable(mux_sel_o)); // R8

  AST_START_CLEARS_DAI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> !dai_o); // R10

  AST_SW_CLEARS_DAI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dai_clr_i && !busy_o) |=> !dai_o); // R10

  AST_NOT_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && shdn_o)); // R6
endmodule

bind adc_seq_ctrl adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .dai_clr_i(dai_clr_i),
  .busy_o   (busy_o),
  .shdn_o   (shdn_o),
  .adc_clk_o(adc_clk_o),
  .conv_go_o(conv_go_o),
  .dai_o    (dai_o),
  .mux_sel_o(mux_sel_o)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int NUM_CH = 16, NUM_BUF = 24, CH_W = 4, IDX_W = 5, CFGW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cont = 0, dai_clr = 0;
  logic [3:0] div_sel = 0;
  logic [7:0] acq_ext = 0, dai_thr = 0;
  logic [IDX_W-1:0] seq_last = 0, rd_idx = 0;
  logic [NUM_BUF*CH_W-1:0] seq_ch = '0;
  logic [NUM_CH*CFGW-1:0]  ch_cfg = '0;
  logic [12:0] code = '0;
  logic adc_clk, conv_go, diff, busy, shdn, dai;
  logic [CH_W-1:0] mux_sel;
  logic [1:0] gain;
  logic [15:0] rd_data;

  int unsigned cyc = 0, code_n = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [12:0] gen(int unsigned n);
    return 13'((n * 1237 + 91) % 8192);
  endfunction

  function automatic int exp_buf(int unsigned n, bit left);
    int avg;
    avg = (int'(gen(n)) + int'(gen(n + 1))) >> 1;
    return left ? (avg << 3) : avg;
  endfunction

  // converter stub: a fresh code per conversion
  always @(posedge clk) if (conv_go) begin
    code   <= gen(code_n);
    code_n <= code_n + 1;
  end

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cont_i(cont),
    .div_sel_i(div_sel), .acq_ext_i(acq_ext), .seq_last_i(seq_last),
    .seq_ch_i(seq_ch), .ch_cfg_i(ch_cfg), .dai_thr_i(dai_thr),
    .dai_clr_i(dai_clr), .code_i(code), .rd_idx_i(rd_idx),
    .adc_clk_o(adc_clk), .conv_go_o(conv_go), .mux_sel_o(mux_sel),
    .diff_o(diff), .gain_o(gain), .busy_o(busy), .shdn_o(shdn),
    .dai_o(dai), .rd_data_o(rd_data)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_slot(int k, int ch);
    seq_ch[k*CH_W +: CH_W] = CH_W'(ch);
  endtask

  task automatic set_cfg(int c, bit d, bit l, bit e, int g);
    ch_cfg[c*CFGW +: CFGW] = {d, l, e, 2'(g)};
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_go(output int unsigned t);
    t = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (conv_go) begin t = cyc; return; end
    end
    chk(0, "R2", "conv_go timeout", 0, 1);
  endtask

  task automatic wait_shdn(output int unsigned t);
    t = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (shdn) begin t = cyc; return; end
    end
    chk(0, "R6", "shutdown timeout", 0, 1);
  endtask

  task automatic rd_chk(int k, int exp, string req);
    rd_idx = IDX_W'(k);
    #1;
    chk(int'(rd_data) == exp, req, $sformatf("buffer %0d", k), int'(rd_data), exp);
  endtask

  task automatic t_reset();
    chk(busy == 0 && shdn == 0, "R12", "busy/shdn after reset", {busy, shdn}, 0);
    chk(dai == 0 && conv_go == 0 && adc_clk == 0, "R12", "dai/go/clk after reset",
        {dai, conv_go, adc_clk}, 0);
    rd_chk(0, 0, "R5");
    rd_chk(23, 0, "R5");
  endtask

  task automatic setup_four();
    set_slot(0, 2);  set_cfg(2, 0, 0, 0, 1);
    set_slot(1, 5);  set_cfg(5, 1, 1, 0, 2);
    set_slot(2, 9);  set_cfg(9, 0, 1, 0, 3);
    set_slot(3, 15); set_cfg(15, 1, 0, 0, 0);
    seq_last = 3; cont = 0; div_sel = 0; acq_ext = 0;
  endtask

  task automatic t_single();
    int unsigned t, tp, ts, n0;
    int chs[4] = '{2, 5, 9, 15};
    bit ds[4] = '{0, 1, 0, 1};
    bit ls[4] = '{0, 1, 1, 0};
    int gs[4] = '{1, 2, 3, 0};
    setup_four(); dai_thr = 0;
    n0 = code_n;
    pulse_start();
    chk(busy == 1, "R11", "busy after start", busy, 1);
    tp = 0;
    for (int g = 0; g < 8; g++) begin
      wait_go(t);
      chk(int'(mux_sel) == chs[g/2], "R8", "mux_sel", mux_sel, chs[g/2]);
      chk(diff == ds[g/2] && int'(gain) == gs[g/2], "R8", "diff/gain",
          {diff, gain}, {ds[g/2], 2'(gs[g/2])});
      if (g > 0) chk(t - tp == 125, "R2", "conv_go spacing", t - tp, 125);
      tp = t;
    end
    wait_shdn(ts);
    chk(ts - tp == 124, "R6", "shutdown delay", ts - tp, 124);
    chk(busy == 0, "R6", "busy in shutdown", busy, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (adc_clk) begin chk(0, "R6", "adc_clk in shutdown", 1, 0); break; end
    end
    for (int k = 0; k < 4; k++) rd_chk(k, exp_buf(n0 + 2*k, ls[k]), "R3 R4 R5");
    rd_chk(24, 0, "R5");
    rd_chk(4, 0, "R5");
  endtask

  task automatic measure(output int unsigned gap, output int rises, output int hi);
    int unsigned t0;
    bit prev = 0;
    int run = 0;
    rises = 0; hi = 0; gap = 0;
    wait_go(t0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (adc_clk && !prev) rises++;
      run = adc_clk ? run + 1 : 0;
      if (run > hi) hi = run;
      prev = adc_clk;
      if (conv_go) begin gap = cyc - t0; return; end
    end
    chk(0, "R1", "measure timeout", 0, 1);
  endtask

  task automatic t_ext_div();
    int unsigned gap, ts;
    int rises, hi;
    set_slot(0, 7); set_cfg(7, 0, 0, 1, 0);
    seq_last = 0; cont = 0; div_sel = 2; acq_ext = 5;
    pulse_start();
    measure(gap, rises, hi);
    chk(gap == 160, "R9", "gap with extension", gap, 160);
    chk(rises == 15, "R1", "converter clock rises", rises, 15);
    chk(hi == 5, "R1", "high phase length", hi, 5);
    wait_shdn(ts);
    set_cfg(7, 0, 0, 0, 0);
    pulse_start();
    measure(gap, rises, hi);
    chk(gap == 155, "R9", "gap with extension off", gap, 155);
    wait_shdn(ts);
  endtask

  task automatic t_cont();
    int unsigned t, n0;
    set_slot(0, 3); set_slot(1, 11);
    set_cfg(3, 0, 0, 0, 0); set_cfg(11, 0, 1, 0, 0);
    seq_last = 1; cont = 1; div_sel = 0; acq_ext = 0;
    n0 = code_n;
    pulse_start();
    for (int g = 0; g < 10; g++) begin
      wait_go(t);
      if (g == 4 || g == 8) chk(mux_sel == 3, "R7", "wrap to slot 0", mux_sel, 3);
      if (g == 6) chk(mux_sel == 11, "R7", "slot 1 second sweep", mux_sel, 11);
      if (shdn) chk(0, "R7", "shutdown in continuous", 1, 0);
    end
    chk(busy == 1 && shdn == 0, "R7", "still running", {busy, shdn}, 2);
    rd_chk(0, exp_buf(n0 + 4, 0), "R7");
    rd_chk(1, exp_buf(n0 + 6, 1), "R7");
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
  endtask

  task automatic t_dai();
    int unsigned t, tp, ts;
    setup_four(); dai_thr = 3;
    pulse_start();
    for (int g = 0; g < 8; g++) begin
      wait_go(t);
      if (g == 5) chk(dai == 0, "R10", "dai before third store", dai, 0);
      if (g == 6) chk(dai == 1, "R10", "dai after third store", dai, 1);
    end
    wait_shdn(ts);
    chk(dai == 1, "R10", "dai holds", dai, 1);
    @(negedge clk) dai_clr = 1;
    @(negedge clk) dai_clr = 0;
    chk(dai == 0, "R10", "software clear", dai, 0);
    dai_thr = 1;
    pulse_start();
    tp = 0;
    for (int g = 0; g < 8; g++) begin
      wait_go(t);
      tp = t;
      if (g == 2) begin
        chk(dai == 1, "R10", "dai after first store", dai, 1);
        pulse_start();
        chk(dai == 1, "R11", "dai kept on busy start", dai, 1);
        chk(busy == 1, "R11", "run continues", busy, 1);
      end
      if (g == 3) chk(mux_sel == 5, "R11", "slot order kept", mux_sel, 5);
    end
    wait_shdn(ts);
    chk(ts - tp == 124, "R11", "run length unchanged", ts - tp, 124);
    chk(dai == 1, "R10", "dai set at end", dai, 1);
    pulse_start();
    chk(dai == 0, "R10", "start clears dai", dai, 0);
    wait_shdn(ts);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_ext_div();
    t_cont();
    t_dai();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule